// File: doc/BRIEF.md
# Context-Tagged Multi-Page-Size Translation Buffer

This block is a fully associative translation buffer of 64 entries shared by two independent lookup ports, one for instruction fetches and one for data accesses. Each entry pairs a virtual tag (page-aligned virtual address plus a 13-bit context number) with a translation word. The translation word holds the physical page, a page-size code and a set of permission and attribute flags. Entries are installed or replaced by a direct indexed write. Miss handling is left to software, which also reads entries back through an indexed read port.

A lookup takes one cycle and all results are registered. The data port chooses its context from a primary, secondary or nucleus space. It reports a physical address, a byte-swap attribute and a writable flag, or one of three trap codes: miss, access fault or write-protection fault. On a fault it records a fault status word, the faulting address and a tag-access word. On a miss it updates only the tag-access word. The instruction port works the same way with two trap codes: miss and privilege fault. Its context is zero whenever the trap level is nonzero.

Top module: `ctx_tlb`

## Requirements
- R1: An entry matches when its valid bit (translation bit 63) is set, and it is either global (bit 0) or its tag bits [12:0] equal the lookup context, and the virtual address and the tag agree under the page mask. The page mask clears the low 13+3*s bits, where s is the size field in bits [62:61]: 0 gives 8 KB, 1 gives 64 KB, 2 gives 512 KB and 3 gives 4 MB.
- R2: On a successful hit the physical address is 41 bits wide. Above the page offset it takes the translation word's bits; inside the page offset it takes the virtual address bits; bits [12:0] are zero. Trap code 0 means success.
- R3: The data context is the primary context for space 0, the secondary context for space 1, and 0 for spaces 2 and 3. The instruction context is the primary context when the trap level is zero and 0 otherwise.
- R4: When several entries match, the entry with the lowest index is used.
- R5: A data hit raises trap code 2 in three cases: a user access to a privileged page (bit 2); a non-faulting load to a side-effect page (bit 5); any other access to a non-faulting-only page (bit 60). Each cause sets its own status bit (7, 8, 9 respectively), and several may be set together.
- R6: A data store that hits a page whose writable bit (bit 1) is clear, when no trap-code-2 cause applies, raises trap code 3.
- R7: A miss gives trap code 1 on the data port or 4 on the instruction port. The port's tag-access word is loaded with {VA[63:13], context}. The fault status and fault address are left unchanged.
- R8: A data trap of code 2 or 3 writes the fault status as follows: bit 0 valid; bit 1 overwrite, set when valid was still set and no clear arrived in that cycle; bits [3:2] context class (0 primary, 1 secondary, 2 nucleus); bit 4 store; bit 5 non-faulting load; bit 6 privileged (not user); plus the cause bits. It also loads the fault address and the tag-access word. A clear request with no fault zeroes the status.
- R9: An instruction hit on a privileged page by a user raises trap code 5. The instruction status records valid, overwrite, privilege, the context class (2 when the trap level is nonzero, else 0) and cause bit 7, and the instruction tag-access word is loaded.
- R10: Every successful hit sets the used bit (translation bit 10) of the selected entry, which is visible through the read port one cycle after the index is presented.
- R11: On success the byte-swap output follows the invert-endian bit (bit 59) and the writable output follows bit 1. On any trap both are 0 and the physical address is 0.
- R12: A result appears exactly one cycle after its request. A write to an entry is seen by lookups from the next cycle on.
- R13: After reset all entries read as zero, no result is flagged and all status, address and tag-access outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_tag | input | 64 | Tag: VA[63:13] and context[12:0] |
| wr_tte | input | 64 | Translation word |
| rd_idx | input | 6 | Entry index to read back |
| rd_tte | output | 64 | Registered translation word of rd_idx |
| pri_ctx | input | 13 | Primary context |
| sec_ctx | input | 13 | Secondary context |
| d_req | input | 1 | Data lookup request |
| d_va | input | 64 | Data virtual address |
| d_space | input | 2 | Context space select |
| d_user | input | 1 | Access made in user mode |
| d_write | input | 1 | Store access |
| d_nf | input | 1 | Non-faulting load |
| d_fsr_clr | input | 1 | Clear data fault status |
| d_done | output | 1 | Data result valid |
| d_trap | output | 3 | Data trap code |
| d_pa | output | 41 | Data physical address |
| d_swap | output | 1 | Byte-swap attribute |
| d_wok | output | 1 | Page writable |
| d_fsr | output | 10 | Data fault status |
| d_far | output | 64 | Data fault address |
| d_tagacc | output | 64 | Data tag-access word |
| i_req | input | 1 | Instruction lookup request |
| i_va | input | 64 | Instruction virtual address |
| i_user | input | 1 | Fetch made in user mode |
| i_tl_nz | input | 1 | Trap level nonzero |
| i_fsr_clr | input | 1 | Clear instruction fault status |
| i_done | output | 1 | Instruction result valid |
| i_trap | output | 3 | Instruction trap code |
| i_pa | output | 41 | Instruction physical address |
| i_fsr | output | 10 | Instruction fault status |
| i_tagacc | output | 64 | Instruction tag-access word |

## Verification
Some properties are checked on every cycle: one-cycle result latency, alignment of a successful address, and that a fault records its address with the valid and overwrite bits set correctly. They also check that a miss leaves the status and address untouched, and that the attributes stay low on a trap. Only the bench's scenarios can show the rest. That covers which entry wins among several matches, the masked compare at each page size, the context choice per space and trap level, the exact cause bits, and the used-bit update. These require a model of the table contents, so the bench compares them against its own copy built from random and directed writes.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W     = 64;
  localparam int TTE_W    = 64;
  localparam int PG_SHIFT = 13;
  localparam int FSR_W    = 10;

  // translation word fields
  localparam int TB_VALID = 63;
  localparam int TB_SZ_HI = 62;
  localparam int TB_SZ_LO = 61;
  localparam int TB_NFO   = 60;
  localparam int TB_IE    = 59;
  localparam int TB_USED  = 10;
  localparam int TB_SE    = 5;
  localparam int TB_PRIV  = 2;
  localparam int TB_WR    = 1;
  localparam int TB_GLOB  = 0;

  // fault status fields
  localparam int FS_V     = 0;
  localparam int FS_OW    = 1;
  localparam int FS_CT_LO = 2;
  localparam int FS_WR    = 4;
  localparam int FS_NF    = 5;
  localparam int FS_PR    = 6;
  localparam int FS_FPRIV = 7;
  localparam int FS_FNFSE = 8;
  localparam int FS_FNFO  = 9;

  typedef enum logic [2:0] {
    TR_NONE   = 3'd0,
    TR_DMISS  = 3'd1,
    TR_DFAULT = 3'd2,
    TR_DPROT  = 3'd3,
    TR_IMISS  = 3'd4,
    TR_IFAULT = 3'd5
  } trap_t;

  function automatic logic [VA_W-1:0] page_mask(input logic [1:0] sz);
    return ~((64'd1 << (PG_SHIFT + 3 * int'(sz))) - 64'd1);
  endfunction

  function automatic logic [VA_W-1:0] phys_of(input logic [TTE_W-1:0] tte,
                                              input logic [VA_W-1:0] va);
    logic [VA_W-1:0] m, full;
    m    = page_mask(tte[TB_SZ_HI:TB_SZ_LO]);
    full = (tte & m) | (va & ~m);
    return {full[VA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
  endfunction
endpackage

// File: rtl/tlb_match_vec.sv
module tlb_match_vec
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int CTX_W   = 13
) (
  input  logic [VA_W-1:0]  tags [ENTRIES],
  input  logic [TTE_W-1:0] ttes [ENTRIES],
  input  logic [VA_W-1:0]  va,
  input  logic [CTX_W-1:0] ctx,
  output logic [ENTRIES-1:0] hit
);
  for (genvar k = 0; k < ENTRIES; k++) begin : g_ent
    logic [VA_W-1:0] msk;
    logic            ctx_ok;
    assign msk    = page_mask(ttes[k][TB_SZ_HI:TB_SZ_LO]);
    assign ctx_ok = ttes[k][TB_GLOB] || (tags[k][CTX_W-1:0] == ctx);
    assign hit[k] = ttes[k][TB_VALID] && ctx_ok && ((va & msk) == (tags[k] & msk));
  end
endmodule

// File: rtl/tlb_prio_pick.sv
module tlb_prio_pick #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |req;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) idx = IW'(k);
    end
  end
endmodule

// File: rtl/tlb_access_check.sv
module tlb_access_check
  import tlb_pkg::*;
(
  input  logic [TTE_W-1:0] tte,
  input  logic             user,
  input  logic             write,
  input  logic             nf_load,
  output logic             f_priv,
  output logic             f_nfse,
  output logic             f_nfo,
  output logic             fault,
  output logic             prot
);
  always_comb begin
    f_priv = tte[TB_PRIV] & user;
    f_nfse = nf_load & tte[TB_SE];
    f_nfo  = ~nf_load & tte[TB_NFO];
    fault  = f_priv | f_nfse | f_nfo;
    prot   = ~fault & write & ~tte[TB_WR];
  end
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int CTX_W   = 13,
  parameter int PA_W    = 41,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [VA_W-1:0]  wr_tag,
  input  logic [TTE_W-1:0] wr_tte,
  input  logic [IW-1:0]    rd_idx,
  output logic [TTE_W-1:0] rd_tte,
  input  logic [CTX_W-1:0] pri_ctx,
  input  logic [CTX_W-1:0] sec_ctx,
  input  logic             d_req,
  input  logic [VA_W-1:0]  d_va,
  input  logic [1:0]       d_space,
  input  logic             d_user,
  input  logic             d_write,
  input  logic             d_nf,
  input  logic             d_fsr_clr,
  output logic             d_done,
  output logic [2:0]       d_trap,
  output logic [PA_W-1:0]  d_pa,
  output logic             d_swap,
  output logic             d_wok,
  output logic [FSR_W-1:0] d_fsr,
  output logic [VA_W-1:0]  d_far,
  output logic [VA_W-1:0]  d_tagacc,
  input  logic             i_req,
  input  logic [VA_W-1:0]  i_va,
  input  logic             i_user,
  input  logic             i_tl_nz,
  input  logic             i_fsr_clr,
  output logic             i_done,
  output logic [2:0]       i_trap,
  output logic [PA_W-1:0]  i_pa,
  output logic [FSR_W-1:0] i_fsr,
  output logic [VA_W-1:0]  i_tagacc
);
  logic [VA_W-1:0]  tag_q [ENTRIES];
  logic [TTE_W-1:0] tte_q [ENTRIES];

  // ---------------- data path ----------------
  logic [CTX_W-1:0]   d_ctx;
  logic [1:0]         d_cls;
  logic [ENTRIES-1:0] d_hitv;
  logic               d_found;
  logic [IW-1:0]      d_idx;
  logic [TTE_W-1:0]   d_sel;
  logic               d_nfe, d_fpriv, d_fnfse, d_fnfo, d_flt, d_prot, d_ok, d_ev;

  always_comb begin
    unique case (d_space)
      2'd0:    begin d_ctx = pri_ctx; d_cls = 2'd0; end
      2'd1:    begin d_ctx = sec_ctx; d_cls = 2'd1; end
      default: begin d_ctx = '0;      d_cls = 2'd2; end
    endcase
  end

  tlb_match_vec #(.ENTRIES(ENTRIES), .CTX_W(CTX_W)) u_dmatch (
    .tags(tag_q), .ttes(tte_q), .va(d_va), .ctx(d_ctx), .hit(d_hitv));
  tlb_prio_pick #(.N(ENTRIES), .IW(IW)) u_dpick (
    .req(d_hitv), .found(d_found), .idx(d_idx));

  assign d_sel = tte_q[d_idx];
  assign d_nfe = d_nf & ~d_write;

  tlb_access_check u_dchk (
    .tte(d_sel), .user(d_user), .write(d_write), .nf_load(d_nfe),
    .f_priv(d_fpriv), .f_nfse(d_fnfse), .f_nfo(d_fnfo), .fault(d_flt), .prot(d_prot));

  assign d_ok = d_req & d_found & ~d_flt & ~d_prot;
  assign d_ev = d_req & d_found & (d_flt | d_prot);

  // ---------------- instruction path ----------------
  logic [CTX_W-1:0]   i_ctx;
  logic [ENTRIES-1:0] i_hitv;
  logic               i_found;
  logic [IW-1:0]      i_idx;
  logic [TTE_W-1:0]   i_sel;
  logic               i_flt, i_ok, i_ev;

  assign i_ctx = i_tl_nz ? '0 : pri_ctx;

  tlb_match_vec #(.ENTRIES(ENTRIES), .CTX_W(CTX_W)) u_imatch (
    .tags(tag_q), .ttes(tte_q), .va(i_va), .ctx(i_ctx), .hit(i_hitv));
  tlb_prio_pick #(.N(ENTRIES), .IW(IW)) u_ipick (
    .req(i_hitv), .found(i_found), .idx(i_idx));

  assign i_sel = tte_q[i_idx];
  assign i_flt = i_sel[TB_PRIV] & i_user;
  assign i_ok  = i_req & i_found & ~i_flt;
  assign i_ev  = i_req & i_found & i_flt;

  // ---------------- entry storage ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < ENTRIES; k++) begin
        tag_q[k] <= '0;
        tte_q[k] <= '0;
      end
      rd_tte <= '0;
    end else begin
      for (int k = 0; k < ENTRIES; k++) begin
        if (wr_en && wr_idx == IW'(k)) begin
          tag_q[k] <= wr_tag;
          tte_q[k] <= wr_tte;
        end else if ((d_ok && d_idx == IW'(k)) || (i_ok && i_idx == IW'(k))) begin
          tte_q[k][TB_USED] <= 1'b1;
        end
      end
      rd_tte <= tte_q[rd_idx];
    end
  end

  // ---------------- data results and fault state ----------------
  logic [FSR_W-1:0] d_fsr_new;
  always_comb begin
    d_fsr_new = '0;
    d_fsr_new[FS_V]                 = 1'b1;
    d_fsr_new[FS_OW]                = d_fsr[FS_V] & ~d_fsr_clr;
    d_fsr_new[FS_CT_LO+1:FS_CT_LO]  = d_cls;
    d_fsr_new[FS_WR]                = d_write;
    d_fsr_new[FS_NF]                = d_nfe;
    d_fsr_new[FS_PR]                = ~d_user;
    d_fsr_new[FS_FPRIV]             = d_fpriv;
    d_fsr_new[FS_FNFSE]             = d_fnfse;
    d_fsr_new[FS_FNFO]              = d_fnfo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      d_done <= 1'b0; d_trap <= TR_NONE; d_pa <= '0; d_swap <= 1'b0; d_wok <= 1'b0;
      d_fsr <= '0; d_far <= '0; d_tagacc <= '0;
    end else begin
      d_done <= d_req;
      d_pa   <= d_ok ? phys_of(d_sel, d_va)[PA_W-1:0] : '0;
      d_swap <= d_ok & d_sel[TB_IE];
      d_wok  <= d_ok & d_sel[TB_WR];
      if (!d_req)        d_trap <= TR_NONE;
      else if (!d_found) d_trap <= TR_DMISS;
      else if (d_flt)    d_trap <= TR_DFAULT;
      else if (d_prot)   d_trap <= TR_DPROT;
      else               d_trap <= TR_NONE;
      if (d_ev) begin
        d_fsr <= d_fsr_new;
        d_far <= d_va;
      end else if (d_fsr_clr) begin
        d_fsr <= '0;
      end
      if (d_req && (d_ev || !d_found))
        d_tagacc <= {d_va[VA_W-1:PG_SHIFT], PG_SHIFT'(d_ctx)};
    end
  end

  // ---------------- instruction results and fault state ----------------
  logic [FSR_W-1:0] i_fsr_new;
  always_comb begin
    i_fsr_new = '0;
    i_fsr_new[FS_V]                = 1'b1;
    i_fsr_new[FS_OW]               = i_fsr[FS_V] & ~i_fsr_clr;
    i_fsr_new[FS_CT_LO+1:FS_CT_LO] = i_tl_nz ? 2'd2 : 2'd0;
    i_fsr_new[FS_PR]               = ~i_user;
    i_fsr_new[FS_FPRIV]            = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      i_done <= 1'b0; i_trap <= TR_NONE; i_pa <= '0; i_fsr <= '0; i_tagacc <= '0;
    end else begin
      i_done <= i_req;
      i_pa   <= i_ok ? phys_of(i_sel, i_va)[PA_W-1:0] : '0;
      if (!i_req)        i_trap <= TR_NONE;
      else if (!i_found) i_trap <= TR_IMISS;
      else if (i_flt)    i_trap <= TR_IFAULT;
      else               i_trap <= TR_NONE;
      if (i_ev)           i_fsr <= i_fsr_new;
      else if (i_fsr_clr) i_fsr <= '0;
      if (i_req && (i_ev || !i_found))
        i_tagacc <= {i_va[VA_W-1:PG_SHIFT], PG_SHIFT'(i_ctx)};
    end
  end
endmodule

// File: rtl/ctx_tlb_chk.sv
module ctx_tlb_chk
  import tlb_pkg::*;
#(
  parameter int PA_W = 41
) (
  input logic             clk,
  input logic             rst,
  input logic             d_req,
  input logic [VA_W-1:0]  d_va,
  input logic             d_fsr_clr,
  input logic             d_done,
  input logic [2:0]       d_trap,
  input logic [PA_W-1:0]  d_pa,
  input logic             d_swap,
  input logic             d_wok,
  input logic [FSR_W-1:0] d_fsr,
  input logic [VA_W-1:0]  d_far,
  input logic [VA_W-1:0]  d_tagacc,
  input logic             i_req,
  input logic             i_tl_nz,
  input logic             i_done,
  input logic [2:0]       i_trap,
  input logic [FSR_W-1:0] i_fsr,
  input logic [VA_W-1:0]  i_tagacc
);
  logic d_fault;
  assign d_fault = d_done && (d_trap == TR_DFAULT || d_trap == TR_DPROT);

  // R12
  d_latency_chk: assert property (@(posedge clk) disable iff (rst) d_req |=> d_done);
  // R12
  i_latency_chk: assert property (@(posedge clk) disable iff (rst) i_req |=> i_done);
  // R13
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!d_done && !i_done && d_fsr == '0 && i_fsr == '0));
  // R2
  pa_align_chk: assert property (@(posedge clk) disable iff (rst)
    (d_done && d_trap == TR_NONE) |-> d_pa[PG_SHIFT-1:0] == '0);
  // R8
  fault_record_chk: assert property (@(posedge clk) disable iff (rst)
    d_fault |-> (d_fsr[FS_V] && d_far == $past(d_va)));
  // R8
  overwrite_chk: assert property (@(posedge clk) disable iff (rst)
    (d_fault && $past(d_fsr[FS_V]) && !$past(d_fsr_clr)) |-> d_fsr[FS_OW]);
  // R7
  miss_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (d_done && d_trap == TR_DMISS && !$past(d_fsr_clr)) |->
      ($stable(d_fsr) && $stable(d_far) && d_tagacc[VA_W-1:PG_SHIFT] == $past(d_va[VA_W-1:PG_SHIFT])));
  // R11
  attr_on_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (d_done && d_trap != TR_NONE) |-> (!d_swap && !d_wok && d_pa == '0));
  // R9
  ifault_status_chk: assert property (@(posedge clk) disable iff (rst)
    (i_done && i_trap == TR_IFAULT) |-> (i_fsr[FS_V] && i_fsr[FS_FPRIV]));
  // R3
  nucleus_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (i_done && i_trap == TR_IMISS && $past(i_tl_nz)) |-> i_tagacc[PG_SHIFT-1:0] == '0);
endmodule

bind ctx_tlb ctx_tlb_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst(rst), .d_req(d_req), .d_va(d_va), .d_fsr_clr(d_fsr_clr),
  .d_done(d_done), .d_trap(d_trap), .d_pa(d_pa), .d_swap(d_swap), .d_wok(d_wok),
  .d_fsr(d_fsr), .d_far(d_far), .d_tagacc(d_tagacc),
  .i_req(i_req), .i_tl_nz(i_tl_nz), .i_done(i_done), .i_trap(i_trap),
  .i_fsr(i_fsr), .i_tagacc(i_tagacc));

// File: tb/ctx_tlb_test.sv
module ctx_tlb_test;
  import tlb_pkg::*;
  localparam int N = 64, CTXW = 13, PAW = 41, IW = 6;

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic wr_en = 0; logic [IW-1:0] wr_idx = 0; logic [63:0] wr_tag = 0, wr_tte = 0;
  logic [IW-1:0] rd_idx = 0; logic [63:0] rd_tte;
  logic [CTXW-1:0] pri_ctx = 13'd7, sec_ctx = 13'd9;
  logic d_req = 0, d_user = 0, d_write = 0, d_nf = 0, d_fsr_clr = 0;
  logic [63:0] d_va = 0; logic [1:0] d_space = 0;
  logic d_done, d_swap, d_wok; logic [2:0] d_trap; logic [PAW-1:0] d_pa;
  logic [FSR_W-1:0] d_fsr; logic [63:0] d_far, d_tagacc;
  logic i_req = 0, i_user = 0, i_tl_nz = 0, i_fsr_clr = 0; logic [63:0] i_va = 0;
  logic i_done; logic [2:0] i_trap; logic [PAW-1:0] i_pa; logic [FSR_W-1:0] i_fsr;
  logic [63:0] i_tagacc;

  ctx_tlb uut (.*);

  logic [63:0] m_tag [N], m_tte [N];
  logic [FSR_W-1:0] m_dfsr = 0, m_ifsr = 0;
  logic [63:0] m_dfar = 0, m_dtag = 0, m_itag = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mask_of(input logic [1:0] s);
    return ~((64'd1 << (13 + 3 * int'(s))) - 1);
  endfunction

  function automatic logic [40:0] exp_pa(input logic [63:0] t, input logic [63:0] va);
    logic [63:0] m, f;
    m = mask_of(t[62:61]);
    f = (t & m) | (va & ~m);
    return {f[40:13], 13'b0};
  endfunction

  function automatic int find(input logic [63:0] va, input logic [12:0] ctx);
    for (int k = 0; k < N; k++) begin
      logic [63:0] m;
      m = mask_of(m_tte[k][62:61]);
      if (m_tte[k][63] && (m_tte[k][0] || m_tag[k][12:0] == ctx) && ((va & m) == (m_tag[k] & m)))
        return k;
    end
    return -1;
  endfunction

  task automatic wr_entry(input int idx, input logic [63:0] tg, input logic [63:0] tt);
    @(negedge clk); wr_en = 1; wr_idx = IW'(idx); wr_tag = tg; wr_tte = tt;
    @(negedge clk); wr_en = 0;
    m_tag[idx] = tg; m_tte[idx] = tt;
  endtask

  task automatic rd_check(input int idx);
    @(negedge clk); rd_idx = IW'(idx);
    @(negedge clk);
    chk("R10 readback", rd_tte, m_tte[idx]);
  endtask

  task automatic data_op(input logic [63:0] va, input logic [1:0] sp, input bit usr,
                         input bit wr, input bit nf, input bit clr, input string lbl);
    logic [12:0] ctx; int idx; logic [2:0] et; logic [40:0] epa; bit esw, ewk, nfe;
    bit fp, fse, fno; logic [63:0] t; string tg;
    ctx = (sp == 0) ? pri_ctx : (sp == 1) ? sec_ctx : 13'd0;
    idx = find(va, ctx);
    nfe = nf & ~wr; epa = 0; esw = 0; ewk = 0;
    if (idx < 0) begin
      et = TR_DMISS; tg = "R7"; m_dtag = {va[63:13], ctx};
      if (clr) m_dfsr = 0;
    end else begin
      t = m_tte[idx];
      fp = t[2] & usr; fse = nfe & t[5]; fno = ~nfe & t[60];
      if (fp | fse | fno) begin et = TR_DFAULT; tg = "R5"; end
      else if (wr & ~t[1]) begin et = TR_DPROT; tg = "R6"; end
      else begin et = TR_NONE; tg = "R2"; end
      if (et == TR_NONE) begin
        epa = exp_pa(t, va); esw = t[59]; ewk = t[1];
        m_tte[idx][10] = 1'b1;
        if (clr) m_dfsr = 0;
      end else begin
        m_dfsr = {fno, fse, fp, ~usr, nfe, wr, ((sp == 0) ? 2'd0 : (sp == 1) ? 2'd1 : 2'd2),
                  m_dfsr[0] & ~clr, 1'b1};
        m_dfar = va; m_dtag = {va[63:13], ctx};
      end
    end
    @(negedge clk);
    d_req = 1; d_va = va; d_space = sp; d_user = usr; d_write = wr; d_nf = nf; d_fsr_clr = clr;
    @(negedge clk);
    d_req = 0; d_fsr_clr = 0;
    chk({lbl, " R12 done"}, 64'(d_done), 64'd1);
    chk({lbl, " ", tg, " trap"}, 64'(d_trap), 64'(et));
    chk({lbl, " R2 pa"}, 64'(d_pa), 64'(epa));
    chk({lbl, " R11 swap/wok"}, {62'd0, d_swap, d_wok}, {62'd0, esw, ewk});
    chk({lbl, " R8 fsr"}, 64'(d_fsr), 64'(m_dfsr));
    chk({lbl, " R8 far"}, d_far, m_dfar);
    chk({lbl, " R7 tagacc"}, d_tagacc, m_dtag);
  endtask

  task automatic inst_op(input logic [63:0] va, input bit usr, input bit tl, input string lbl);
    logic [12:0] ctx; int idx; logic [2:0] et; logic [40:0] epa;
    ctx = tl ? 13'd0 : pri_ctx;
    idx = find(va, ctx); epa = 0;
    if (idx < 0) begin
      et = TR_IMISS; m_itag = {va[63:13], ctx};
    end else if (m_tte[idx][2] & usr) begin
      et = TR_IFAULT;
      m_ifsr = {3'b001, ~usr, 2'b00, (tl ? 2'd2 : 2'd0), m_ifsr[0], 1'b1};
      m_itag = {va[63:13], ctx};
    end else begin
      et = TR_NONE; epa = exp_pa(m_tte[idx], va); m_tte[idx][10] = 1'b1;
    end
    @(negedge clk); i_req = 1; i_va = va; i_user = usr; i_tl_nz = tl;
    @(negedge clk); i_req = 0;
    chk({lbl, " R12 idone"}, 64'(i_done), 64'd1);
    chk({lbl, " R9 itrap"}, 64'(i_trap), 64'(et));
    chk({lbl, " R2 ipa"}, 64'(i_pa), 64'(epa));
    chk({lbl, " R9 ifsr"}, 64'(i_fsr), 64'(m_ifsr));
    chk({lbl, " R7 itagacc"}, i_tagacc, m_itag);
  endtask

  function automatic logic [63:0] base_va(input int k);
    return {24'h0, 8'(k * 37 + 3), 32'h0};
  endfunction

  function automatic logic [63:0] rnd_tte();
    logic [27:0] pa;
    pa = 28'($urandom());
    return {($urandom() % 8) != 0, 2'($urandom()), ($urandom() % 4) == 0, 1'($urandom()),
            18'b0, pa, 2'b0, 1'($urandom()), 4'b0, ($urandom() % 4) == 0, 2'b0,
            1'($urandom()), 1'($urandom()), ($urandom() % 6) == 0};
  endfunction

  localparam logic [63:0] VA4M = 64'h0000_0012_3440_0000;
  localparam logic [63:0] VAG  = 64'h0000_0000_0040_2000;
  localparam logic [63:0] VA64 = 64'h0000_0000_8001_0000;

  initial begin
    for (int k = 0; k < N; k++) begin m_tag[k] = 0; m_tte[k] = 0; end
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R13 reset state
    chk("R13 d_done", 64'(d_done), 0);
    chk("R13 d_fsr", 64'(d_fsr), 0);
    chk("R13 i_fsr", 64'(i_fsr), 0);
    chk("R13 tagacc", d_tagacc, 0);
    rd_check(0);
    data_op(VA4M, 0, 0, 0, 0, 0, "R13 empty");

    // R1 R4 4 MB pages, lowest index wins
    wr_entry(5, VA4M | 64'd7, 64'h8000_0000_0000_0000 | (64'h3 << 61) | 64'h0000_01AB_CDC0_0000 | 64'h2);
    wr_entry(9, VA4M | 64'd7, 64'hE000_0000_0000_0000 | 64'h0000_0100_0000_0000 | 64'h2);
    data_op(VA4M + 64'h3A_BCDE, 0, 0, 0, 0, 0, "R1 R4 lowest");
    wr_entry(5, VA4M | 64'd7, 64'h0);
    data_op(VA4M + 64'h3A_BCDE, 0, 0, 1, 0, 0, "R4 next");
    data_op(VA4M + 64'h10_0000, 1, 0, 0, 0, 0, "R3 secondary miss");

    // R5 R6 R8 R11 global 8 KB side-effect page
    wr_entry(12, VAG | 64'd55, 64'h8000_0000_0000_0000 | (64'h1 << 59) | 64'h7654_2000 | 64'h25);
    data_op(VAG, 2, 1, 0, 1, 0, "R5 two causes");
    data_op(VAG, 0, 1, 0, 1, 0, "R8 overwrite");
    data_op(VAG, 1, 0, 1, 0, 0, "R6 store");
    data_op(VAG + 64'h2000, 0, 0, 0, 0, 0, "R7 miss keeps status");
    data_op(VAG + 64'h1FFF, 0, 0, 0, 0, 1, "R1 R11 global clear");
    data_op(VAG, 0, 0, 0, 0, 0, "R8 cleared");
    rd_check(12);
    rd_check(9);

    // R3 R9 instruction path
    inst_op(VA4M + 64'h8000, 0, 0, "R3 primary fetch");
    inst_op(VA4M + 64'h8000, 0, 1, "R3 nucleus fetch");
    wr_entry(20, VA64, 64'h8000_0000_0000_0000 | (64'h1 << 61) | 64'h0003_1230_0000 | 64'h4);
    inst_op(VA64 + 64'hE123, 1, 1, "R9 user priv");
    inst_op(VA64 + 64'hE123, 1, 1, "R9 overwrite");
    inst_op(VA64 + 64'h4000, 0, 1, "R1 64K");
    rd_check(20);

    // random phase
    for (int k = 0; k < N; k++) begin
      logic [12:0] c;
      case ($urandom() % 4)
        0: c = pri_ctx; 1: c = sec_ctx; 2: c = 0; default: c = 13'($urandom());
      endcase
      wr_entry(k, base_va($urandom() % 4) | (64'($urandom()) & 64'h3F_E000) | 64'(c), rnd_tte());
    end
    for (int n = 0; n < 800; n++) begin
      logic [63:0] va;
      va = base_va($urandom() % 4) | (64'($urandom()) & 64'h3F_FFFF);
      case ($urandom() % 8)
        0: inst_op(va, 1'($urandom()), 1'($urandom()), "rnd");
        1: rd_check($urandom() % N);
        2: wr_entry($urandom() % N, base_va($urandom() % 4) | (64'($urandom()) & 64'h3F_E000) |
                    64'(($urandom() % 2) ? pri_ctx : 13'd0), rnd_tte());
        default: data_op(va, 2'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()),
                         ($urandom() % 5) == 0, "rnd");
      endcase
    end
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired R12 actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule